// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block runs single accesses to DRAM attached to a microcontroller-style external bus. A processor-side request carries an address, a read/write flag, write data and the number of the target region. Only regions 2 to 5 may hold DRAM. The block accepts the request only while idle. It then steps through a fixed cycle: precharge, row, first column, second column. During that cycle it drives a multiplexed row/column address, uses the selected region's chip-select line as the row strobe, pulses the column strobe, and drives a write-enable strobe. Read data is captured at the end of the cycle, and a one-cycle completion pulse follows.

Each region has its own wait-enable bit. This bit never changes the four base states. It only decides whether the external wait input may stretch the cycle between the two column states. All strobes are active low. The write-data bus is modelled as a data output plus an output-enable.

Top module: `dram_seq`

## Requirements
- R1: While reset is asserted and straight after it is released, every chip-select, the column strobe and the write strobe are high, the data output-enable is low, ready is high and done is low.
- R2: Without wait states, one access takes exactly four clock states from acceptance to the end of the cycle. Done is high in the fifth cycle after the accepting edge.
- R3: The states always run in this order: precharge (all strobes high, address 0), row, first column, second column.
- R4: Chip-select line n (n = region number, bit n of the select bus) goes low from the row state through the second column state and acts as the row strobe. No other select line goes low.
- R5: In the row state the address output equals the request address shifted right by COL_W. In the column and wait states it equals the low COL_W address bits, zero-extended.
- R6: The column strobe is low only in the second column state, and only while the row strobe is also low.
- R7: For a write, the write strobe is low from the first column state through the second column state. For a read it stays high.
- R8: For a write, the output-enable is high and the data output carries the request's write data from the first column state through the second column state. For a read, the output-enable stays low.
- R9: When the wait-enable bit of the addressed region is 0, the wait input has no effect, and the second column state always follows the first.
- R10: When the region's wait-enable bit is 1 and the wait input is low at the end of the first column state, wait states are inserted. Each wait state repeats the column address with the column strobe high. The second column state follows the first wait state in which the wait input is high.
- R11: For a read, the data input is captured at the end of the second column state and appears on the read-data output together with a one-cycle done pulse.
- R12: A request is accepted only in the idle state and only for regions 2 to 5. Requests made during an access, or naming any other region, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_wdata_i | input | DATA_W | Write data |
| req_region_i | input | $clog2(NUM_CS) | Target region number |
| wait_en_i | input | NUM_CS | Per-region wait-enable bits |
| wait_n_i | input | 1 | External wait, low = hold |
| ready_o | output | 1 | Idle, a request may be accepted |
| done_o | output | 1 | One-cycle access completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| mem_addr_o | output | max(ADDR_W-COL_W, COL_W) | Multiplexed row/column address |
| cs_n_o | output | NUM_CS | Chip-selects, row strobe for DRAM regions |
| cas_n_o | output | 1 | Column strobe |
| we_n_o | output | 1 | Write strobe |
| dq_o | output | DATA_W | Write data bus |
| dq_oe_o | output | 1 | Data bus output-enable |
| dq_i | input | DATA_W | Read data bus |

## Verification
The bench builds the block with COL_W = 10, the widest column setting, together with the default 24-bit address and 16-bit data. This gives a 14-bit row field that is wider than the column field, so the zero-extension of the column and the split at bit 10 are both visible. With eight chip-select lines, all four DRAM regions can be addressed, and so can out-of-range regions on either side. Table-driven accesses cover reads and writes, every DRAM region, and zero to three wait states. Directed cases cover a disabled wait bit combined with a low wait input, requests made during a busy cycle, and requests to non-DRAM regions.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ROW  = 3'd2,
    ST_COL1 = 3'd3,
    ST_WAIT = 3'd4,
    ST_COL2 = 3'd5
  } dseq_state_e;
endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wait_gate,
  input  logic        wait_n,
  output dseq_state_e state
);
  dseq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_PRE;
      ST_PRE:  state_d = ST_ROW;
      ST_ROW:  state_d = ST_COL1;
      ST_COL1: state_d = (wait_gate && !wait_n) ? ST_WAIT : ST_COL2;
      ST_WAIT: state_d = wait_n ? ST_COL2 : ST_WAIT;
      ST_COL2: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  p_start_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start) |=> state_q == ST_PRE);
  p_pre_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PRE |=> state_q == ST_ROW);
  p_row_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ROW |=> state_q == ST_COL1);
  p_nowait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COL1 && !wait_gate) |=> state_q == ST_COL2);
  p_hold_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !wait_n) |=> state_q == ST_WAIT);
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COL1) |=> state_q != ST_PRE);
endmodule

// File: rtl/dram_seq_addr_mux.sv
module dram_seq_addr_mux
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int COL_W  = 9,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dseq_state_e       state,
  input  logic [ADDR_W-1:0] addr,
  output logic [MUX_W-1:0]  mux_addr
);
  logic [MUX_W-1:0] row_ext;
  logic [MUX_W-1:0] col_ext;

  always_comb begin
    row_ext = '0;
    col_ext = '0;
    row_ext[ROW_W-1:0] = addr[ADDR_W-1:COL_W];
    col_ext[COL_W-1:0] = addr[COL_W-1:0];
    unique case (state)
      ST_ROW:                    mux_addr = row_ext;
      ST_COL1, ST_WAIT, ST_COL2: mux_addr = col_ext;
      default:                   mux_addr = '0;
    endcase
  end

  p_pre_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PRE |-> mux_addr == '0);
  p_col_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> $stable(mux_addr));
endmodule

// File: rtl/dram_seq_strobes.sv
module dram_seq_strobes
  import dram_seq_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int REG_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dseq_state_e       state,
  input  logic [REG_W-1:0]  region,
  input  logic              is_write,
  output logic [NUM_CS-1:0] cs_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              dq_oe
);
  logic ras_phase;
  logic col_phase;

  assign ras_phase = (state == ST_ROW) || (state == ST_COL1) ||
                     (state == ST_WAIT) || (state == ST_COL2);
  assign col_phase = (state == ST_COL1) || (state == ST_WAIT) ||
                     (state == ST_COL2);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(ras_phase && (region == REG_W'(g)));
  end

  assign cas_n = !(state == ST_COL2);
  assign we_n  = !(is_write && col_phase);
  assign dq_oe = is_write && col_phase;

  p_ras_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_cas_in_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (cs_n != '1));
  p_cas_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |=> cas_n);
  p_we_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_write |-> (we_n && !dq_oe));
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int COL_W     = 9,
  parameter int NUM_CS    = 8,
  parameter int DRAM_LO   = 2,
  parameter int DRAM_HI   = 5,
  localparam int REG_W    = $clog2(NUM_CS),
  localparam int ROW_W    = ADDR_W - COL_W,
  localparam int MUX_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [REG_W-1:0]  req_region_i,
  input  logic [NUM_CS-1:0] wait_en_i,
  input  logic              wait_n_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MUX_W-1:0]  mem_addr_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  dseq_state_e state;

  logic              start;
  logic              region_ok;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [REG_W-1:0]  region_q;
  logic              we_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              done_q, done_d;
  logic              cap_en;

  assign ready_o   = (state == ST_IDLE);
  assign region_ok = (req_region_i >= REG_W'(DRAM_LO)) &&
                     (req_region_i <= REG_W'(DRAM_HI));
  assign start     = req_i && ready_o && region_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      region_q <= '0;
      we_q     <= 1'b0;
    end else if (start) begin
      addr_q   <= req_addr_i;
      wdata_q  <= req_wdata_i;
      region_q <= req_region_i;
      we_q     <= req_we_i;
    end
  end

  assign cap_en = (state == ST_COL2) && !we_q;

  always_comb begin
    rdata_d = cap_en ? dq_i : rdata_q;
    done_d  = (state == ST_COL2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      done_q  <= done_d;
    end
  end

  assign rdata_o = rdata_q;
  assign done_o  = done_q;
  assign dq_o    = wdata_q;

  dram_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wait_gate (wait_en_i[region_q]),
    .wait_n    (wait_n_i),
    .state     (state)
  );

  dram_seq_addr_mux #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_amux (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .addr     (addr_q),
    .mux_addr (mem_addr_o)
  );

  dram_seq_strobes #(.NUM_CS(NUM_CS)) u_strb (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .region   (region_q),
    .is_write (we_q),
    .cs_n     (cs_n_o),
    .cas_n    (cas_n_o),
    .we_n     (we_n_o),
    .dq_oe    (dq_oe_o)
  );

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_after_cas_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_o |=> done_o);
  p_bad_region_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !region_ok) |=> ready_o);
endmodule

// File: tb/sim_dram_seq.sv
module sim_dram_seq;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int COL_W  = 10;
  localparam int NUM_CS = 8;
  localparam int REG_W  = 3;
  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int NV     = 6;

  localparam logic        V_WE   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [2:0]  V_REG  [NV] = '{3'd2, 3'd3, 3'd4, 3'd5, 3'd2, 3'd5};
  localparam logic [23:0] V_ADDR [NV] = '{24'h123456, 24'hABCDEF, 24'hFFFFFF,
                                          24'h0003FF, 24'h800400, 24'h5A5A5A};
  localparam logic [15:0] V_WD   [NV] = '{16'h1111, 16'hBEEF, 16'h2222,
                                          16'hC0DE, 16'h3333, 16'hF00D};
  localparam logic [15:0] V_RD   [NV] = '{16'hA5A5, 16'h0000, 16'h5A5A,
                                          16'h0000, 16'hFFFF, 16'h0000};
  localparam int          V_WT   [NV] = '{0, 0, 2, 1, 3, 0};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [REG_W-1:0]  req_region;
  logic [NUM_CS-1:0] wait_en;
  logic              wait_n;
  logic              ready, done, cas_n, we_n, dq_oe;
  logic [DATA_W-1:0] rdata, dq_out, dq_in;
  logic [MUX_W-1:0]  maddr;
  logic [NUM_CS-1:0] cs_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dram_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .NUM_CS(NUM_CS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_region_i(req_region), .wait_en_i(wait_en),
    .wait_n_i(wait_n), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(maddr), .cs_n_o(cs_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_chk(string tag);
    chk({tag, " cs idle"}, 32'(cs_n), 32'hFF);
    chk({tag, " cas idle"}, 32'(cas_n), 1);
    chk({tag, " we idle"}, 32'(we_n), 1);
    chk({tag, " oe idle"}, 32'(dq_oe), 0);
  endtask

  // waits: cycles the wait input is held low; en: region wait bit; poke: request while busy
  task automatic access(logic we, logic [2:0] rg, logic [23:0] a, logic [15:0] wd,
                        logic [15:0] rd, int waits, logic en, logic poke);
    logic [MUX_W-1:0] rowx, colx;
    logic [NUM_CS-1:0] csx;
    int eff;
    rowx = MUX_W'(a >> COL_W);
    colx = MUX_W'(a[COL_W-1:0]);
    csx  = ~(NUM_CS'(1) << rg);
    eff  = en ? waits : 0;
    wait_en = en ? 8'h3C : 8'h00;
    req = 1; req_we = we; req_addr = a; req_wdata = wd; req_region = rg;
    @(negedge clk);
    req = poke; req_addr = ~a; req_region = (rg == 3'd2) ? 3'd4 : 3'd2; req_we = ~we;
    // precharge
    chk("R3 pre cs", 32'(cs_n), 32'hFF);
    chk("R3 pre addr", 32'(maddr), 0);
    chk("R3 pre cas", 32'(cas_n), 1);
    chk("R2 busy", 32'(ready), 0);
    wait_n = (waits == 0);
    @(negedge clk);
    chk("R4 row cs", 32'(cs_n), 32'(csx));
    chk("R5 row addr", 32'(maddr), 32'(rowx));
    chk("R6 row cas", 32'(cas_n), 1);
    chk("R7 row we", 32'(we_n), 1);
    @(negedge clk);
    chk("R5 col1 addr", 32'(maddr), 32'(colx));
    chk("R4 col1 cs", 32'(cs_n), 32'(csx));
    chk("R6 col1 cas", 32'(cas_n), 1);
    chk("R7 col1 we", 32'(we_n), 32'(!we));
    chk("R8 col1 oe", 32'(dq_oe), 32'(we));
    if (we) chk("R8 col1 data", 32'(dq_out), 32'(wd));
    if (!en && waits > 0) wait_n = 0;
    for (int i = 0; i < eff; i++) begin
      @(negedge clk);
      chk("R10 wait cas", 32'(cas_n), 1);
      chk("R10 wait addr", 32'(maddr), 32'(colx));
      chk("R10 wait cs", 32'(cs_n), 32'(csx));
      chk("R8 wait oe", 32'(dq_oe), 32'(we));
      wait_n = (i == eff - 1);
    end
    @(negedge clk);
    chk(en ? "R10 col2 cas" : "R9 col2 cas", 32'(cas_n), 0);
    chk("R4 col2 cs", 32'(cs_n), 32'(csx));
    chk("R5 col2 addr", 32'(maddr), 32'(colx));
    chk("R7 col2 we", 32'(we_n), 32'(!we));
    if (we) chk("R8 col2 data", 32'(dq_out), 32'(wd));
    dq_in = rd; wait_n = 1; req = 0;
    @(negedge clk);
    dq_in = 16'h0BAD;
    chk("R11 done", 32'(done), 1);
    chk("R2 ready", 32'(ready), 1);
    if (!we) chk("R11 rdata", 32'(rdata), 32'(rd));
    idle_chk("R3 end");
    @(negedge clk);
    chk("R11 done pulse", 32'(done), 0);
    chk("R12 no late start", 32'(ready), 1);
  endtask

  initial begin
    rst_n = 0; req = 0; req_we = 0; req_addr = '0; req_wdata = '0; req_region = '0;
    wait_en = '0; wait_n = 1; dq_in = '0;
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    chk("R1 ready", 32'(ready), 1);
    chk("R1 done", 32'(done), 0);
    rst_n = 1;
    @(negedge clk);
    idle_chk("R1 after reset");
    // table walk
    for (int v = 0; v < NV; v++)
      access(V_WE[v], V_REG[v], V_ADDR[v], V_WD[v], V_RD[v], V_WT[v], 1'b1, 1'b0);
    // R9: wait bit off, wait input low for several cycles
    access(1'b0, 3'd3, 24'h00F00F, 16'h0, 16'h7E7E, 3, 1'b0, 1'b0);
    // R12: request held during a busy access
    access(1'b1, 3'd4, 24'h345678, 16'h4321, 16'h0, 1, 1'b1, 1'b1);
    // R12: non-DRAM regions ignored
    for (int r = 0; r < 8; r++) begin
      if (r < 2 || r > 5) begin
        req = 1; req_region = 3'(r); req_addr = 24'h111111;
        @(negedge clk);
        req = 0;
        chk("R12 bad region", 32'(ready), 1);
        chk("R12 bad region cs", 32'(cs_n), 32'hFF);
        @(negedge clk);
        chk("R12 bad region stays", 32'(ready), 1);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule